// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block picks which of eight interrupt lines, if any, should be raised to the processor. Its inputs are a vector of pending requests and a mask vector. It keeps two pieces of state: an in-service vector and a 3-bit rotation base. Priority is relative to the base. The line whose number equals the base ranks highest, and the ranks fall off going upward and wrap around. A request is raised only when the best unmasked request outranks every line already in service. The resolver output is combinational from the registered state and the inputs.

On an acknowledge, the chosen line is either marked in service, or, in auto end-of-interrupt mode, left clear. Rotate-on-auto-EOI can then move the base to the line just after the acknowledged one. An acknowledge with nothing to grant reports line 7 as a spurious interrupt. When the block is the primary unit in a cascade, a nested option stops the cascade line's in-service bit from blocking further requests. A clear vector, driven by the end-of-interrupt logic outside, and a base load port complete the state interface.

Top module: `irq_rotprio_resolver`

## Requirements
- R1: After reset the in-service vector `svc_vec` is all zero, `rot_base` is 0 and `irq_out` is low.
- R2: Only lines with `req_vec` bit 1 and `mask_vec` bit 0 are candidates. A masked line is never reported on `irq_line`.
- R3: The rank of line n is (n − `rot_base`) mod 8, and rank 0 is the highest. `irq_line` names the candidate with the lowest rank.
- R4: `irq_out` is high only when the best candidate rank is strictly below the rank of the highest-ranked in-service line. An empty in-service vector counts as rank 8. Equal ranks do not raise the output.
- R5: With `nested_en` high, the primary unit ignores in-service bit 2 (the cascade line) when it computes the in-service rank. With `nested_en` low, that bit blocks like any other.
- R6: An `ack` while `irq_out` is high and `auto_eoi_en` is low sets bit `irq_line` of `svc_vec` at the next clock edge.
- R7: An `ack` while `auto_eoi_en` is high leaves `svc_vec` unchanged.
- R8: If `auto_eoi_en` and `rot_aeoi_en` are both high, an `ack` with `irq_out` high sets `rot_base` to (`irq_line` + 1) mod 8 at the next edge. With `auto_eoi_en` low, `rot_base` does not move.
- R9: While `irq_out` is low, `ack_line` reads 7. An `ack` in that state changes neither `svc_vec` nor `rot_base`. While `irq_out` is high, `ack_line` equals `irq_line`.
- R10: `svc_clear` bits clear the matching `svc_vec` bits at the next edge. `base_load` loads `base_in` into `rot_base` at the next edge and takes precedence over rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vec | input | 8 | Pending request lines |
| mask_vec | input | 8 | Per-line mask, 1 blocks the line |
| nested_en | input | 1 | Ignore the cascade line's in-service bit |
| auto_eoi_en | input | 1 | Acknowledge does not mark the line in service |
| rot_aeoi_en | input | 1 | Rotate the base on auto-EOI acknowledge |
| ack | input | 1 | Processor acknowledge strobe |
| svc_clear | input | 8 | Bits to clear in the in-service vector |
| base_load | input | 1 | Load a new rotation base |
| base_in | input | 3 | Rotation base to load |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_line | output | 3 | Winning line when irq_out is high |
| ack_line | output | 3 | Line reported on acknowledge (7 if spurious) |
| svc_vec | output | 8 | In-service vector |
| rot_base | output | 3 | Current rotation base |

## Verification
`irq_out`, `irq_line` and `ack_line` follow the inputs in the same cycle. The bench therefore drives each request and mask pattern just after a falling edge and samples it 1 ns later, before any rising edge can arrive. Effects of `ack`, `svc_clear` and `base_load` on `svc_vec` and `rot_base` are due one rising edge after the strobe, so the bench holds the strobe across exactly one rising edge and samples at the following falling edge. The sweeps cover every rotation base against every request pattern. They run with an empty in-service vector, with each single in-service line, and with the cascade bit in service both with and without nested mode.

// File: rtl/rp_pkg.sv
package rp_pkg;
   // Outcome of one acknowledge cycle, decided by the service register
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,   // no acknowledge, or nothing to grant
      ACK_HOLD  = 2'd1,   // granted, line enters service
      ACK_AUTO  = 2'd2    // granted, auto end-of-interrupt
   } ack_kind_t;
endpackage

// File: rtl/rp_rank_finder.sv
module rp_rank_finder #(
   parameter int N  = 8,
   localparam int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [LW-1:0] base,
   output logic          found,
   output logic [LW:0]   rank,
   output logic [LW-1:0] line
);
   initial begin
      assert (N >= 2 && (N & (N - 1)) == 0)
         else $error("rp_rank_finder: N must be a power of two");
   end

   // Scan ranks from lowest priority to highest so the highest one wins last
   always_comb begin
      logic [LW-1:0] idx;
      found = 1'b0;
      rank  = (LW + 1)'(N);
      line  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         idx = base + LW'(k);
         if (vec[idx]) begin
            found = 1'b1;
            rank  = (LW + 1)'(k);
            line  = idx;
         end
      end
   end

   // R3: a reported line is always one that is set in the vector
   always_comb begin
      if (found) a_r3_line_present: assert (vec[line]);
   end
endmodule

// File: rtl/rp_service_reg.sv
module rp_service_reg
   import rp_pkg::*;
#(
   parameter int N  = 8,
   localparam int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          grant,
   input  logic [LW-1:0] grant_line,
   input  logic          auto_eoi_en,
   input  logic          rot_aeoi_en,
   input  logic [N-1:0]  clear_vec,
   input  logic          base_load,
   input  logic [LW-1:0] base_in,
   output logic [N-1:0]  svc_q,
   output logic [LW-1:0] base_q
);
   ack_kind_t     kind;
   logic [N-1:0]  set_vec;

   always_comb begin
      if (!grant)          kind = ACK_IDLE;
      else if (auto_eoi_en) kind = ACK_AUTO;
      else                 kind = ACK_HOLD;
      set_vec = '0;
      if (kind == ACK_HOLD) set_vec[grant_line] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         svc_q  <= '0;
         base_q <= '0;
      end else begin
         svc_q <= (svc_q & ~clear_vec) | set_vec;
         if (base_load)
            base_q <= base_in;
         else if (kind == ACK_AUTO && rot_aeoi_en)
            base_q <= grant_line + LW'(1);
      end
   end

   // R6: a held grant marks its line in service
   a_r6_hold_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !auto_eoi_en) |=> svc_q[$past(grant_line)]);
   // R7: auto-EOI grants and clears only ever remove bits
   a_r7_auto_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant || auto_eoi_en) |=> ((svc_q & ~$past(svc_q)) == '0));
   // R8: rotation after auto-EOI grant
   a_r8_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && auto_eoi_en && rot_aeoi_en && !base_load)
      |=> base_q == LW'($past(grant_line) + LW'(1)));
   // R8: without auto-EOI the base holds unless loaded
   a_r8_no_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_eoi_en && !base_load) |=> $stable(base_q));
   // R10: load wins over rotation
   a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
      base_load |=> base_q == $past(base_in));
endmodule

// File: rtl/irq_rotprio_resolver.sv
module irq_rotprio_resolver #(
   parameter int N          = 8,
   parameter int CASC_LINE  = 2,
   parameter bit IS_PRIMARY = 1'b1,
   localparam int LW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req_vec,
   input  logic [N-1:0]  mask_vec,
   input  logic          nested_en,
   input  logic          auto_eoi_en,
   input  logic          rot_aeoi_en,
   input  logic          ack,
   input  logic [N-1:0]  svc_clear,
   input  logic          base_load,
   input  logic [LW-1:0] base_in,
   output logic          irq_out,
   output logic [LW-1:0] irq_line,
   output logic [LW-1:0] ack_line,
   output logic [N-1:0]  svc_vec,
   output logic [LW-1:0] rot_base
);
   initial begin
      assert (CASC_LINE >= 0 && CASC_LINE < N)
         else $error("irq_rotprio_resolver: CASC_LINE out of range");
   end

   logic [N-1:0]  cand_vec;
   logic [N-1:0]  svc_eff;
   logic          cand_found, svc_found;
   logic [LW:0]   cand_rank, svc_rank;
   logic [LW-1:0] svc_line;

   assign cand_vec = req_vec & ~mask_vec;

   // The nested option exists only on the primary unit of a cascade
   generate
      if (IS_PRIMARY) begin : g_primary
         logic [N-1:0] casc_bit;
         assign casc_bit = N'(1) << CASC_LINE;
         assign svc_eff  = nested_en ? (svc_vec & ~casc_bit) : svc_vec;
      end else begin : g_secondary
         assign svc_eff = svc_vec;
      end
   endgenerate

   rp_rank_finder #(.N(N)) u_cand (
      .vec(cand_vec), .base(rot_base),
      .found(cand_found), .rank(cand_rank), .line(irq_line)
   );

   rp_rank_finder #(.N(N)) u_svc (
      .vec(svc_eff), .base(rot_base),
      .found(svc_found), .rank(svc_rank), .line(svc_line)
   );

   assign irq_out  = cand_found && (cand_rank < svc_rank);
   assign ack_line = irq_out ? irq_line : LW'(N - 1);

   rp_service_reg #(.N(N)) u_svc_reg (
      .clk(clk), .rst_n(rst_n),
      .grant(ack && irq_out), .grant_line(irq_line),
      .auto_eoi_en(auto_eoi_en), .rot_aeoi_en(rot_aeoi_en),
      .clear_vec(svc_clear), .base_load(base_load), .base_in(base_in),
      .svc_q(svc_vec), .base_q(rot_base)
   );

   // R2: a raised line is requested and unmasked
   a_r2_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (req_vec[irq_line] && !mask_vec[irq_line]));
   // R4: a raised line is never itself in service
   a_r4_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> !svc_eff[irq_line]);
   // R4: whenever anything is in service and raised, the winner outranks it
   a_r4_outranks: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && svc_found) |-> (irq_line != svc_line));
   // R9: a spurious acknowledge leaves state untouched
   a_r9_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !irq_out && svc_clear == '0 && !base_load)
      |=> ($stable(svc_vec) && $stable(rot_base)));
endmodule

// File: tb/irq_rotprio_resolver_bench.sv
module irq_rotprio_resolver_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_vec = '0, mask_vec = '0, svc_clear = '0;
   logic       nested_en = 0, auto_eoi_en = 0, rot_aeoi_en = 0, ack = 0, base_load = 0;
   logic [2:0] base_in = '0;
   logic       irq_out;
   logic [2:0] irq_line, ack_line, rot_base;
   logic [7:0] svc_vec;

   int n_chk = 0, n_bad = 0;
   logic [7:0] m_svc;
   int         m_base;

   always #4 clk = ~clk;

   irq_rotprio_resolver u_irq_rotprio_resolver (
      .clk(clk), .rst_n(rst_n), .req_vec(req_vec), .mask_vec(mask_vec),
      .nested_en(nested_en), .auto_eoi_en(auto_eoi_en), .rot_aeoi_en(rot_aeoi_en),
      .ack(ack), .svc_clear(svc_clear), .base_load(base_load), .base_in(base_in),
      .irq_out(irq_out), .irq_line(irq_line), .ack_line(ack_line),
      .svc_vec(svc_vec), .rot_base(rot_base)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // rank of the highest-priority set bit, 8 if none
   function automatic int top_rank(logic [7:0] v, int b);
      for (int k = 0; k < 8; k++) if (v[(k + b) % 8]) return k;
      return 8;
   endfunction

   task automatic check_resolve(string req);
      int cr, sr, ev, el;
      logic [7:0] s;
      s  = nested_en ? (m_svc & 8'hFB) : m_svc;
      cr = top_rank(req_vec & ~mask_vec, m_base);
      sr = top_rank(s, m_base);
      ev = (cr < 8 && cr < sr) ? 1 : 0;
      el = ev ? (cr + m_base) % 8 : 7;
      check(req, int'(irq_out), ev);
      check({req, "/R9"}, int'(ack_line), el);
      if (ev) check(req, int'(irq_line), el);
   endtask

   // one-cycle strobe around a single rising edge, sample at the next falling edge
   task automatic pulse_ack();
      ack = 1; @(negedge clk); ack = 0; #1;
   endtask

   task automatic load_base(int b);
      base_in = 3'(b); base_load = 1; @(negedge clk); base_load = 0; #1;
      m_base = b;
      check("R10 base load", int'(rot_base), b);
   endtask

   task automatic clear_all();
      svc_clear = 8'hFF; @(negedge clk); svc_clear = '0; #1;
      m_svc = '0;
      check("R10 clear", int'(svc_vec), 0);
   endtask

   initial begin
      #150000000;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      m_svc = '0; m_base = 0;
      @(negedge clk); #1;
      check("R1 svc reset", int'(svc_vec), 0);
      check("R1 base reset", int'(rot_base), 0);
      check("R1 irq reset", int'(irq_out), 0);
      @(negedge clk); rst_n = 1; @(negedge clk);

      // R2 R3: empty in service, every base, all requests, varying masks
      for (int b = 0; b < 8; b++) begin
         load_base(b);
         for (int r = 0; r < 256; r++) begin
            @(negedge clk);
            req_vec = 8'(r); mask_vec = 8'(r * 29 + b * 7); #1;
            check_resolve("R2/R3 sweep");
         end
      end
      mask_vec = '0;

      // R4 R6: each single in-service line, every base, every request
      for (int b = 0; b < 8; b++) begin
         for (int s = 0; s < 8; s++) begin
            clear_all();
            load_base(b);
            @(negedge clk); req_vec = 8'(1 << s); #1;
            pulse_ack();
            m_svc = 8'(1 << s);
            check("R6 ack sets", int'(svc_vec), int'(m_svc));
            for (int r = 0; r < 256; r++) begin
               @(negedge clk); req_vec = 8'(r); #1;
               check_resolve("R4 sweep");
            end
         end
      end

      // R5: cascade line in service, nested on lets lower-ranked lines through
      clear_all(); load_base(0);
      @(negedge clk); req_vec = 8'h04; #1; pulse_ack(); m_svc = 8'h04;
      nested_en = 1;
      @(negedge clk); req_vec = 8'h20; #1;
      check("R5 nested raise", int'(irq_out), 1);
      pulse_ack(); m_svc = 8'h24;
      check("R5 nested ack", int'(svc_vec), 8'h24);
      for (int nm = 0; nm < 2; nm++) begin
         nested_en = nm[0];
         for (int r = 0; r < 256; r++) begin
            @(negedge clk); req_vec = 8'(r); #1;
            check_resolve("R5 sweep");
         end
      end
      nested_en = 0;
      @(negedge clk); req_vec = 8'h10; #1;
      check("R5 nested off blocks", int'(irq_out), 0);

      // R7 R8: auto-EOI with rotation
      clear_all(); load_base(0);
      auto_eoi_en = 1; rot_aeoi_en = 1;
      @(negedge clk); req_vec = 8'h08; #1;
      pulse_ack();
      check("R7 auto keeps svc", int'(svc_vec), 0);
      check("R8 rotate", int'(rot_base), 4);
      @(negedge clk); req_vec = 8'h18; #1;
      check("R8 new top line", int'(irq_line), 4);
      @(negedge clk); req_vec = 8'h01; #1;
      pulse_ack();
      check("R8 wrap rotate", int'(rot_base), 1);
      // auto-EOI without rotation
      rot_aeoi_en = 0;
      @(negedge clk); req_vec = 8'h40; #1;
      pulse_ack();
      check("R8 no rot flag", int'(rot_base), 1);
      check("R7 auto keeps svc", int'(svc_vec), 0);
      // rotation flag without auto-EOI
      auto_eoi_en = 0; rot_aeoi_en = 1;
      @(negedge clk); req_vec = 8'h40; #1;
      pulse_ack();
      check("R8 no auto no rot", int'(rot_base), 1);
      check("R6 held", int'(svc_vec), 8'h40);
      // load takes precedence over rotation
      auto_eoi_en = 1;
      clear_all();
      @(negedge clk); req_vec = 8'h02; base_in = 3'd6; base_load = 1; ack = 1;
      @(negedge clk); base_load = 0; ack = 0; #1;
      check("R10 load over rotate", int'(rot_base), 6);
      auto_eoi_en = 0; rot_aeoi_en = 0;

      // R9: spurious acknowledge
      @(negedge clk); req_vec = 8'h00; #1;
      check("R9 spurious line", int'(ack_line), 7);
      pulse_ack();
      check("R9 svc unchanged", int'(svc_vec), 0);
      check("R9 base unchanged", int'(rot_base), 6);
      @(negedge clk); req_vec = 8'hFF; mask_vec = 8'hFF; #1;
      check("R2 all masked", int'(irq_out), 0);
      pulse_ack();
      check("R9 masked ack quiet", int'(svc_vec), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule